// File: doc/BRIEF.md
# Per-Bin Spectrum Accumulator

This block sums complex spectra frame after frame. A transform engine streams one sample per cycle, carrying a valid flag, a bin index and signed real and imaginary parts. For each accepted sample the block reads the running sum stored for that bin, adds the sample, and writes the result back to the same address. Real and imaginary sums live in two separate storage arrays. Each narrow input word is widened so that its binary point lines up with the wider accumulator word before the add.

The storage read latency is a parameter. It is zero for a register-built array and one or more for an inferred block RAM. The bin index, sample and flags are delayed to match that latency. A short history of recent writes feeds the newest sum for an address back into the adder when that sum has not yet reached storage. Driving the clear input alongside a sample makes that bin restart from zero. A frame counter records every write to the last bin. A readout request streams all bins in order. The readout issues its storage reads only while no sample is in flight, so every value it returns includes all earlier samples.

Top module: `spec_bin_accum`

## Requirements
- R1: Each sample accepted with in_valid high and clear low adds its aligned real part to the real sum of bin in_bin, and its aligned imaginary part to the imaginary sum of that bin. The two sums are kept separately.
- R2: An input word has IN_W=32 bits in two's complement, with 13 fractional bits. It is sign-extended to ACC_W=64 bits and shifted left by 13, which gives 26 fractional bits. Sums wrap modulo 2^64.
- R3: A sample accepted while clear is high writes zero to both sums of its bin, whatever its data. Bins not addressed while clear is high keep their sums.
- R4: Every accumulated value and the readout order are the same for every RD_LAT value, including 0 and 2.
- R5: Samples to the same bin on consecutive cycles, or closer together than RD_LAT+1 cycles, give the same sums as samples that are widely spaced.
- R6: frame_count is 0 after reset. It rises by exactly one for each sample written to bin BINS-1, RD_LAT+1 cycles after that sample is accepted.
- R7: A rd_req seen while idle produces exactly BINS entries with out_valid high, for bins 0 to BINS-1 in ascending order. out_last is high only on bin BINS-1. A rd_req during a readout is ignored.
- R8: Readout reads wait while a sample is being accepted or is still in flight. Each entry therefore includes every sample accepted before its read.
- R9: While rst is high and directly after it, out_valid and out_last are low, frame_count is 0 and no readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_bin | input | $clog2(BINS) | Bin index of the sample |
| in_re | input | IN_W | Real part, signed fixed point |
| in_im | input | IN_W | Imaginary part, signed fixed point |
| clear | input | 1 | Store zero for this sample's bin |
| rd_req | input | 1 | Start a full-frame readout |
| out_valid | output | 1 | Readout entry present |
| out_last | output | 1 | Entry is bin BINS-1 |
| out_bin | output | $clog2(BINS) | Bin of the readout entry |
| out_re | output | ACC_W | Real sum of that bin |
| out_im | output | ACC_W | Imaginary sum of that bin |
| frame_count | output | FCNT_W | Writes to the last bin since reset |

## Verification
A sample's write completes RD_LAT+1 cycles after it is accepted, so frame_count is checked only after an idle gap well longer than that. Each readout entry appears RD_LAT+1 cycles after its read issues, and that issue point moves whenever samples stall the readout. The bench therefore queues the expected entries in bin order before the first one can appear. A monitor pops and compares an entry on every cycle out_valid is high, and never waits for a fixed cycle. Two instances, with read latencies 0 and 2, take the same stimulus and are compared against one reference model.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic {RO_IDLE = 1'b0, RO_RUN = 1'b1} ro_state_t;
endpackage

// File: rtl/sba_delay.sv
module sba_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          d,
  output logic [DEPTH:0][W-1:0] taps
);
  if (DEPTH == 0) begin : g_wire
    logic unused_clk;
    assign unused_clk = clk | rst;
    assign taps[0] = d;
  end else begin : g_regs
    logic [W-1:0] stg [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
      end else begin
        stg[0] <= d;
        for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      end
    end
    always_comb begin
      taps[0] = d;
      for (int k = 0; k < DEPTH; k++) taps[k+1] = stg[k];
    end
  end
endmodule

// File: rtl/sba_mem.sv
module sba_mem #(
  parameter int DW     = 64,
  parameter int DEPTH  = 1024,
  parameter int RD_LAT = 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  if (RD_LAT == 0) begin : g_async
    assign rdata = ram[raddr];
  end else begin : g_sync
    logic [DW-1:0] q [RD_LAT];
    always_ff @(posedge clk) begin
      q[0] <= ram[raddr];
      for (int k = 1; k < RD_LAT; k++) q[k] <= q[k-1];
    end
    assign rdata = q[RD_LAT-1];
  end
endmodule

// File: rtl/sba_fwd.sv
module sba_fwd #(
  parameter int DW    = 64,
  parameter int AW    = 10,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_re,
  input  logic [DW-1:0] wr_im,
  input  logic [AW-1:0] look_addr,
  input  logic [DW-1:0] mem_re,
  input  logic [DW-1:0] mem_im,
  output logic [DW-1:0] op_re,
  output logic [DW-1:0] op_im
);
  if (DEPTH == 0) begin : g_none
    logic unused_fwd;
    assign unused_fwd = clk | rst | wr_en | (|wr_addr) | (|wr_re) | (|wr_im) | (|look_addr);
    assign op_re = mem_re;
    assign op_im = mem_im;
  end else begin : g_hist
    logic [DEPTH-1:0] hv;
    logic [AW-1:0]    ha [DEPTH];
    logic [DW-1:0]    hr [DEPTH];
    logic [DW-1:0]    hi [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) hv <= '0;
      else begin
        hv[0] <= wr_en;
        for (int k = 1; k < DEPTH; k++) hv[k] <= hv[k-1];
      end
    end

    always_ff @(posedge clk) begin
      ha[0] <= wr_addr;
      hr[0] <= wr_re;
      hi[0] <= wr_im;
      for (int k = 1; k < DEPTH; k++) begin
        ha[k] <= ha[k-1];
        hr[k] <= hr[k-1];
        hi[k] <= hi[k-1];
      end
    end

    // oldest first, so the newest matching write is applied last and wins
    always_comb begin
      op_re = mem_re;
      op_im = mem_im;
      for (int k = DEPTH - 1; k >= 0; k--) begin
        if (hv[k] && ha[k] == look_addr) begin
          op_re = hr[k];
          op_im = hi[k];
        end
      end
    end
  end
endmodule

// File: rtl/spec_bin_accum.sv
module spec_bin_accum
  import sba_pkg::*;
#(
  parameter int BINS     = 1024,
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 13,
  parameter int ACC_W    = 64,
  parameter int ACC_FRAC = 26,
  parameter int RD_LAT   = 1,
  parameter int FCNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [$clog2(BINS)-1:0]  in_bin,
  input  logic [IN_W-1:0]          in_re,
  input  logic [IN_W-1:0]          in_im,
  input  logic                     clear,
  input  logic                     rd_req,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [$clog2(BINS)-1:0]  out_bin,
  output logic [ACC_W-1:0]         out_re,
  output logic [ACC_W-1:0]         out_im,
  output logic [FCNT_W-1:0]        frame_count
);
  localparam int AW    = $clog2(BINS);
  localparam int SHIFT = ACC_FRAC - IN_FRAC;
  localparam int PW    = 2 + AW + 2 * IN_W;
  localparam int RW    = 1 + AW;
  localparam logic [AW-1:0] LAST_BIN = AW'(BINS - 1);

  function automatic logic [ACC_W-1:0] align_in(input logic [IN_W-1:0] x);
    logic [ACC_W-1:0] wide;
    wide = {{(ACC_W - IN_W){x[IN_W-1]}}, x};
    return wide << SHIFT;
  endfunction

  // ---------------- sample pipeline matched to read latency ----------------
  logic [PW-1:0]             smp_in;
  logic [RD_LAT:0][PW-1:0]   smp_tap;
  logic                      s_v, s_clr;
  logic [AW-1:0]             s_bin;
  logic [IN_W-1:0]           s_re, s_im;
  logic                      busy;

  assign smp_in = {in_valid, in_valid & clear, in_bin, in_re, in_im};

  sba_delay #(.W(PW), .DEPTH(RD_LAT)) u_smp_dly (
    .clk (clk), .rst (rst), .d (smp_in), .taps (smp_tap)
  );

  assign {s_v, s_clr, s_bin, s_re, s_im} = smp_tap[RD_LAT];

  always_comb begin
    busy = 1'b0;
    for (int k = 0; k <= RD_LAT; k++) busy = busy | smp_tap[k][PW-1];
  end

  // ---------------- readout sequencer ----------------
  ro_state_t     ro_st;
  logic [AW-1:0] ro_addr;
  logic          ro_issue;

  assign ro_issue = (ro_st == RO_RUN) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ro_st   <= RO_IDLE;
      ro_addr <= '0;
    end else begin
      case (ro_st)
        RO_IDLE: if (rd_req) begin
          ro_st   <= RO_RUN;
          ro_addr <= '0;
        end
        RO_RUN: if (ro_issue) begin
          ro_addr <= ro_addr + 1'b1;
          if (ro_addr == LAST_BIN) ro_st <= RO_IDLE;
        end
        default: ro_st <= RO_IDLE;
      endcase
    end
  end

  logic [RW-1:0]           ro_in;
  logic [RD_LAT:0][RW-1:0] ro_tap;
  logic                    r_v;
  logic [AW-1:0]           r_bin;

  assign ro_in = {ro_issue, ro_addr};

  sba_delay #(.W(RW), .DEPTH(RD_LAT)) u_ro_dly (
    .clk (clk), .rst (rst), .d (ro_in), .taps (ro_tap)
  );

  assign {r_v, r_bin} = ro_tap[RD_LAT];

  // ---------------- storage ----------------
  logic [AW-1:0]    raddr;
  logic [ACC_W-1:0] mem_re, mem_im, op_re, op_im, sum_re, sum_im;

  assign raddr = in_valid ? in_bin : ro_addr;

  sba_mem #(.DW(ACC_W), .DEPTH(BINS), .RD_LAT(RD_LAT)) u_mem_re (
    .clk (clk), .we (s_v), .waddr (s_bin), .wdata (sum_re),
    .raddr (raddr), .rdata (mem_re)
  );

  sba_mem #(.DW(ACC_W), .DEPTH(BINS), .RD_LAT(RD_LAT)) u_mem_im (
    .clk (clk), .we (s_v), .waddr (s_bin), .wdata (sum_im),
    .raddr (raddr), .rdata (mem_im)
  );

  sba_fwd #(.DW(ACC_W), .AW(AW), .DEPTH(RD_LAT)) u_fwd (
    .clk (clk), .rst (rst),
    .wr_en (s_v), .wr_addr (s_bin), .wr_re (sum_re), .wr_im (sum_im),
    .look_addr (s_bin), .mem_re (mem_re), .mem_im (mem_im),
    .op_re (op_re), .op_im (op_im)
  );

  always_comb begin
    if (s_clr) begin
      sum_re = '0;
      sum_im = '0;
    end else begin
      sum_re = op_re + align_in(s_re);
      sum_im = op_im + align_in(s_im);
    end
  end

  // ---------------- frame counter ----------------
  always_ff @(posedge clk) begin
    if (rst) frame_count <= '0;
    else if (s_v && s_bin == LAST_BIN) frame_count <= frame_count + 1'b1;
  end

  // ---------------- registered readout outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_bin   <= '0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= r_v;
      out_last  <= r_v && (r_bin == LAST_BIN);
      out_bin   <= r_bin;
      out_re    <= mem_re;
      out_im    <= mem_im;
    end
  end

  // ---------------- assertions ----------------
  logic          chk_mid;
  logic [AW-1:0] chk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_mid  <= 1'b0;
      chk_prev <= '0;
    end else if (out_valid) begin
      chk_mid  <= !out_last;
      chk_prev <= out_bin;
    end
  end

  assert_first_bin_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !chk_mid) |-> (out_bin == '0));

  assert_bin_order_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && chk_mid) |-> (out_bin == chk_prev + 1'b1));

  assert_last_flag_R7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_bin == LAST_BIN));

  assert_fcnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frame_count == $past(frame_count) || frame_count == $past(frame_count) + 1'b1));
endmodule

// File: tb/spec_bin_accum_tb_top.sv
module spec_bin_accum_tb_top;
  localparam int BINS = 1024;
  localparam int AW   = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, in_valid, clear, rd_req;
  logic [AW-1:0] in_bin;
  logic [31:0]   in_re, in_im;

  logic          v0, l0, v2, l2;
  logic [AW-1:0] b0, b2;
  logic [63:0]   re0, im0, re2, im2;
  logic [15:0]   fc0, fc2;

  spec_bin_accum #(.BINS(BINS), .RD_LAT(0)) dut_l0_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_re(in_re), .in_im(in_im),
    .clear(clear), .rd_req(rd_req), .out_valid(v0), .out_last(l0), .out_bin(b0),
    .out_re(re0), .out_im(im0), .frame_count(fc0));

  spec_bin_accum #(.BINS(BINS), .RD_LAT(2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_re(in_re), .in_im(in_im),
    .clear(clear), .rd_req(rd_req), .out_valid(v2), .out_last(l2), .out_bin(b2),
    .out_re(re2), .out_im(im2), .frame_count(fc2));

  typedef struct {
    int          bin;
    logic [63:0] re;
    logic [63:0] im;
  } exp_t;

  exp_t        q0[$];
  exp_t        q2[$];
  logic [63:0] ref_re [BINS];
  logic [63:0] ref_im [BINS];
  int          checks = 0, errors = 0, fc_exp = 0, n0 = 0, n2 = 0;
  string       tag = "R1";
  bit          done = 1'b0;
  logic [31:0] sd = 32'h1234_5678;

  function automatic logic [31:0] gen();
    sd = sd * 32'h0019_660D + 32'h3C6E_F35F;
    return sd;
  endfunction

  function automatic logic [63:0] al(input logic [31:0] x);
    logic [63:0] e;
    e = {{32{x[31]}}, x};
    return e << 13;
  endfunction

  task automatic cmp(input string who, input exp_t e, input int bin, input logic last,
                     input logic [63:0] re, input logic [63:0] im);
    checks++;
    if (bin != e.bin || re != e.re || im != e.im) begin
      errors++;
      $display("FAIL %s %s bin %0d re %h im %h expected bin %0d re %h im %h",
               tag, who, bin, re, im, e.bin, e.re, e.im);
    end
    checks++;
    if (last != (e.bin == BINS - 1)) begin
      errors++;
      $display("FAIL R7 %s last flag %0b expected %0b at bin %0d", who, last, e.bin == BINS - 1, bin);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (!rst && v0) begin
      exp_t e;
      n0++;
      if (q0.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 lat0 extra entry bin %0d expected none", b0);
      end else begin
        e = q0.pop_front();
        cmp("lat0", e, int'(b0), l0, re0, im0);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && v2) begin
      exp_t e;
      n2++;
      if (q2.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 lat2 extra entry bin %0d expected none", b2);
      end else begin
        e = q2.pop_front();
        cmp("lat2", e, int'(b2), l2, re2, im2);
      end
    end
  end

  task automatic put(input int b, input logic [31:0] re, input logic [31:0] im, input bit clr);
    @(negedge clk);
    in_valid = 1'b1; in_bin = AW'(b); in_re = re; in_im = im; clear = clr; rd_req = 1'b0;
    if (clr) begin
      ref_re[b] = '0; ref_im[b] = '0;
    end else begin
      ref_re[b] = ref_re[b] + al(re); ref_im[b] = ref_im[b] + al(im);
    end
    if (b == BINS - 1) fc_exp++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; clear = 1'b0; rd_req = 1'b0;
    end
  endtask

  task automatic push_all();
    for (int b = 0; b < BINS; b++) begin
      exp_t e;
      e.bin = b; e.re = ref_re[b]; e.im = ref_im[b];
      q0.push_back(e); q2.push_back(e);
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((q0.size() != 0 || q2.size() != 0) && n < 6000) begin
      @(negedge clk); n++;
    end
    idle(12);
  endtask

  task automatic readout(input string t);
    tag = t;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b0; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    push_all();
    drain();
  endtask

  task automatic chk_fc(input string t);
    checks++;
    if (int'(fc0) != fc_exp || int'(fc2) != fc_exp) begin
      errors++;
      $display("FAIL %s frame_count lat0 %0d lat2 %0d expected %0d", t, fc0, fc2, fc_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; clear = 1'b0; rd_req = 1'b0;
    in_bin = '0; in_re = '0; in_im = '0;
    for (int b = 0; b < BINS; b++) begin ref_re[b] = '0; ref_im[b] = '0; end
    repeat (5) @(negedge clk);
    checks++;
    if (v0 || v2 || l0 || l2 || fc0 != 0 || fc2 != 0) begin
      errors++;
      $display("FAIL R9 in reset valid %0b/%0b last %0b/%0b fc %0d/%0d expected all 0",
               v0, v2, l0, l2, fc0, fc2);
    end
    rst = 1'b0;
    idle(3);
    checks++;
    if (v0 || v2 || fc0 != 0 || fc2 != 0) begin
      errors++;
      $display("FAIL R9 after reset valid %0b/%0b fc %0d/%0d expected 0", v0, v2, fc0, fc2);
    end

    // R3: whole frame with clear high
    for (int b = 0; b < BINS; b++) put(b, gen(), gen(), 1'b1);
    idle(8);
    chk_fc("R6");
    readout("R3");

    // R1: two accumulating frames
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < BINS; b++) put(b, gen(), gen(), 1'b0);
    idle(8);
    chk_fc("R6");
    readout("R1");

    // R3: clear toggled for part of a frame
    for (int b = 0; b < BINS; b++) put(b, gen(), gen(), (b >= 100 && b < 200));
    idle(8);
    chk_fc("R6");
    readout("R3");

    // R2: sign extension and binary point alignment
    put(10, 32'h0, 32'h0, 1'b1);
    put(10, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    put(11, 32'h0, 32'h0, 1'b1);
    put(11, 32'h8000_0000, 32'h0000_0001, 1'b0);
    checks++;
    if (ref_re[10] != 64'hFFFF_FFFF_FFFF_E000 || ref_im[11] != 64'h0000_0000_0000_2000) begin
      errors++;
      $display("FAIL R2 model re %h im %h expected FFFFFFFFFFFFE000 0000000000002000",
               ref_re[10], ref_im[11]);
    end
    idle(4);
    readout("R2");

    // R5: same-address hazards at distance 1, 2, 3 and with a gap
    for (int k = 0; k < 6; k++) put(5, gen(), gen(), 1'b0);
    put(7, gen(), gen(), 1'b0); put(8, gen(), gen(), 1'b0); put(7, gen(), gen(), 1'b0);
    put(8, gen(), gen(), 1'b0); put(9, gen(), gen(), 1'b0); put(7, gen(), gen(), 1'b0);
    put(3, gen(), gen(), 1'b0); put(3, gen(), gen(), 1'b0);
    idle(1);
    put(3, gen(), gen(), 1'b0);
    put(20, gen(), gen(), 1'b0); put(21, gen(), gen(), 1'b0); put(22, gen(), gen(), 1'b0);
    put(20, gen(), gen(), 1'b0);
    put(30, gen(), gen(), 1'b1); put(30, gen(), gen(), 1'b0);
    idle(6);
    readout("R5");

    // R8: samples arriving with the request stall the readout; R7 repeat request ignored
    tag = "R8";
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b1;
    put(BINS - 1, gen(), gen(), 1'b0);
    put(BINS - 2, gen(), gen(), 1'b0);
    put(BINS - 1, gen(), gen(), 1'b0);
    put(0, gen(), gen(), 1'b0);
    put(BINS - 1, gen(), gen(), 1'b0);
    push_all();
    idle(1);
    while (q2.size() > 1000) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    drain();
    idle(30);
    chk_fc("R6");

    checks++;
    if (q0.size() != 0 || q2.size() != 0) begin
      errors++;
      $display("FAIL R7 missing entries lat0 %0d lat2 %0d expected 0", q0.size(), q2.size());
    end
    checks++;
    if (n0 != n2 || n0 != 6 * BINS) begin
      errors++;
      $display("FAIL R4 entry counts lat0 %0d lat2 %0d expected %0d", n0, n2, 6 * BINS);
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule